// File: doc/BRIEF.md
# Power-Mode Clock Enable Controller

This block sits between the power-management state of a device and its clock generation circuitry. A mode code names one of seven power-managed states: run or idle on the main crystal source, run or idle on the low-frequency timer oscillator, run or idle on the on-chip internal sources, or sleep. Side requests from other features also reach the block. These are USB activity, the watchdog, and timers or a real-time clock that need the timer oscillator. The block decides which oscillators must stay powered and which source feeds the device clock. It also sets the postscaler ratio for the fast internal source, and it gates the core and peripheral clocks to match the mode.

Every output is registered. A change on the inputs reaches the outputs on the next rising clock edge as one coherent update, so each enable changes at most once for each mode change. The oscillators, the glitch-free clock multiplexer and all analog circuitry are outside this block.

Top module: `pm_clock_ctrl`

## Requirements
- R1: While reset is asserted, the outputs hold the main-run state: `pri_osc_en`=1, `tmr_osc_en`=0, `fast_rc_en`=0, `slow_rc_en`=0, `clk_sel`=0, `div_out`=0, `core_clk_on`=1, `periph_clk_on`=1.
- R2: The main oscillator is enabled in main-run (mode 0) and main-idle (mode 1). In modes 2 to 6 it is disabled when `usb_on` is 0.
- R3: With `usb_on`=1 the main oscillator is enabled in every mode, sleep included.
- R4: In timer-run (mode 2) and timer-idle (mode 3), `tmr_osc_en`=1 and `clk_sel`=1 (timer oscillator).
- R5: With `tmr_req`=1 the timer oscillator is enabled in every mode, sleep included.
- R6: In internal-run (mode 4) and internal-idle (mode 5) with `slow_pick`=0, `fast_rc_en`=1, `clk_sel`=2 and `div_out` equals `div_in`. In every other case `div_out`=0 (no division).
- R7: In modes 4 and 5 with `slow_pick`=1, `slow_rc_en`=1, `clk_sel`=3 and `fast_rc_en`=0.
- R8: With `wdt_on`=1 the slow internal source is enabled in every mode, sleep included.
- R9: In sleep (mode 6) with no side request, all four oscillator enables are 0 and `clk_sel`=0.
- R10: In run modes (0, 2, 4) both clock gates are on. In idle modes (1, 3, 5) the core gate is off and the peripheral gate is on. In sleep both are off.
- R11: The unused mode code 7 gives exactly the outputs of main-run.
- R12: Outputs change only on a rising clock edge. A new input value becomes visible one clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Power mode code: 0 main-run, 1 main-idle, 2 timer-run, 3 timer-idle, 4 internal-run, 5 internal-idle, 6 sleep, 7 unused |
| usb_on | input | 1 | USB is active and needs the main oscillator |
| wdt_on | input | 1 | Watchdog is active and needs the slow internal source |
| tmr_req | input | 1 | Timers or a real-time clock need the timer oscillator |
| slow_pick | input | 1 | In internal modes, clock the device from the slow source instead of the fast one |
| div_in | input | DIV_W | Requested postscaler setting for the fast internal source |
| pri_osc_en | output | 1 | Main oscillator enable |
| tmr_osc_en | output | 1 | Timer oscillator enable |
| fast_rc_en | output | 1 | Fast internal source enable |
| slow_rc_en | output | 1 | Slow internal source enable |
| clk_sel | output | 2 | Device clock source: 0 main, 1 timer oscillator, 2 fast internal, 3 slow internal |
| div_out | output | DIV_W | Postscaler setting in use |
| core_clk_on | output | 1 | Core clock gate |
| periph_clk_on | output | 1 | Peripheral clock gate |

## Verification
The bench targets the places where side requests override the mode. USB in sleep and in timer modes, the watchdog in main and timer modes, and a timer request in sleep are all exercised. A design that decoded only the mode would drop a source that a live feature still needs. The bench also switches `slow_pick` inside the internal modes. A design that left the fast source running or kept a stale divider there would show a wrong `fast_rc_en` or `div_out`. Mode 7 is checked against main-run so that an unhandled code cannot silently turn off every clock. One check samples just before the edge, which catches outputs that are combinational instead of registered.

// File: rtl/pm_clock_ctrl.sv
module pm_clock_ctrl #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic             usb_on,
  input  logic             wdt_on,
  input  logic             tmr_req,
  input  logic             slow_pick,
  input  logic [DIV_W-1:0] div_in,
  output logic             pri_osc_en,
  output logic             tmr_osc_en,
  output logic             fast_rc_en,
  output logic             slow_rc_en,
  output logic [1:0]       clk_sel,
  output logic [DIV_W-1:0] div_out,
  output logic             core_clk_on,
  output logic             periph_clk_on
);
  localparam logic [2:0] M_PRI_RUN = 3'd0, M_PRI_IDLE = 3'd1, M_TMR_RUN = 3'd2,
                         M_TMR_IDLE = 3'd3, M_INT_RUN = 3'd4, M_INT_IDLE = 3'd5,
                         M_SLEEP = 3'd6;
  localparam logic [1:0] SEL_PRI = 2'd0, SEL_TMR = 2'd1, SEL_FAST = 2'd2, SEL_SLOW = 2'd3;

  wire is_tmr   = (mode == M_TMR_RUN) || (mode == M_TMR_IDLE);
  wire is_int   = (mode == M_INT_RUN) || (mode == M_INT_IDLE);
  wire is_sleep = (mode == M_SLEEP);
  wire is_idle  = (mode == M_PRI_IDLE) || (mode == M_TMR_IDLE) || (mode == M_INT_IDLE);
  wire is_pri   = !is_tmr && !is_int && !is_sleep;
  wire use_fast = is_int && !slow_pick;
  wire use_slow = is_int && slow_pick;

  logic [1:0] sel_d;
  always_comb begin
    sel_d = SEL_PRI;
    if (is_tmr)        sel_d = SEL_TMR;
    else if (use_fast) sel_d = SEL_FAST;
    else if (use_slow) sel_d = SEL_SLOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_osc_en    <= 1'b1;
      tmr_osc_en    <= 1'b0;
      fast_rc_en    <= 1'b0;
      slow_rc_en    <= 1'b0;
      clk_sel       <= SEL_PRI;
      div_out       <= '0;
      core_clk_on   <= 1'b1;
      periph_clk_on <= 1'b1;
    end else begin
      pri_osc_en    <= is_pri || usb_on;
      tmr_osc_en    <= is_tmr || tmr_req;
      fast_rc_en    <= use_fast;
      slow_rc_en    <= use_slow || wdt_on;
      clk_sel       <= sel_d;
      div_out       <= use_fast ? div_in : '0;
      core_clk_on   <= !is_sleep && !is_idle;
      periph_clk_on <= !is_sleep;
    end
  end

  // R2
  pri_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode) == M_PRI_IDLE) |-> pri_osc_en);
  // R3
  usb_keeps_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(usb_on)) |-> pri_osc_en);
  // R8
  wdt_keeps_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wdt_on)) |-> slow_rc_en);
  // R7
  slow_excludes_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == SEL_SLOW) |-> (!fast_rc_en && slow_rc_en));
  // R4
  tmr_src_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == SEL_TMR) |-> tmr_osc_en);
  // R10
  gate_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_on |-> periph_clk_on);
  // R12
  stable_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(mode) && $stable(usb_on) && $stable(wdt_on) && $stable(tmr_req)
     && $stable(slow_pick) && $stable(div_in)) |=> $stable(clk_sel));
endmodule

// File: tb/tb_pm_clock_ctrl.sv
`timescale 1ns/1ps
module tb_pm_clock_ctrl;
  localparam int DIV_W = 3;
  logic clk = 0, rst_n = 0;
  logic [2:0] mode = 0;
  logic usb_on = 0, wdt_on = 0, tmr_req = 0, slow_pick = 0;
  logic [DIV_W-1:0] div_in = 0;
  logic pri_osc_en, tmr_osc_en, fast_rc_en, slow_rc_en, core_clk_on, periph_clk_on;
  logic [1:0] clk_sel;
  logic [DIV_W-1:0] div_out;
  int checks = 0, errors = 0;

  typedef logic [8+DIV_W-1:0] vec_t;
  vec_t exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  pm_clock_ctrl #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .usb_on(usb_on), .wdt_on(wdt_on),
    .tmr_req(tmr_req), .slow_pick(slow_pick), .div_in(div_in),
    .pri_osc_en(pri_osc_en), .tmr_osc_en(tmr_osc_en), .fast_rc_en(fast_rc_en),
    .slow_rc_en(slow_rc_en), .clk_sel(clk_sel), .div_out(div_out),
    .core_clk_on(core_clk_on), .periph_clk_on(periph_clk_on));

  wire vec_t actual = {pri_osc_en, tmr_osc_en, fast_rc_en, slow_rc_en, clk_sel, div_out,
                       core_clk_on, periph_clk_on};

  function automatic vec_t model(input logic [2:0] m, input logic u, w, t, s,
                                 input logic [DIV_W-1:0] d);
    logic p, tm, f, sl, c, pe;
    logic [1:0] sel;
    logic [DIV_W-1:0] dv;
    p = (m == 0 || m == 1 || m == 7) || u;
    tm = (m == 2 || m == 3) || t;
    f = (m == 4 || m == 5) && !s;
    sl = ((m == 4 || m == 5) && s) || w;
    sel = (m == 2 || m == 3) ? 2'd1 : (m == 4 || m == 5) ? (s ? 2'd3 : 2'd2) : 2'd0;
    dv = ((m == 4 || m == 5) && !s) ? d : '0;
    c = (m == 0 || m == 2 || m == 4 || m == 7);
    pe = (m != 6);
    return {p, tm, f, sl, sel, dv, c, pe};
  endfunction

  task automatic check(input string tag, input vec_t got, input vec_t exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic u, w, t, s,
                       input logic [DIV_W-1:0] d, input string tag);
    @(negedge clk);
    mode = m; usb_on = u; wdt_on = w; tmr_req = t; slow_pick = s; div_in = d;
    exp_q.push_back(model(m, u, w, t, s, d));
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && exp_q.size() > 0) check(tag_q.pop_front(), actual, exp_q.pop_front());
  end

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    #7;
    check("R1 reset", actual, 11'b1_0_0_0_00_000_1_1);
    @(negedge clk); rst_n = 1;
    for (int m = 0; m < 7; m++) drive(3'(m), 0, 0, 0, 0, 3'd0, "R2 R10 mode sweep");
    for (int m = 0; m < 8; m++) drive(3'(m), 1, 0, 0, 0, 3'd0, "R3 usb");
    drive(3'd2, 0, 0, 0, 0, 3'd0, "R4 timer run");
    drive(3'd3, 0, 1, 0, 0, 3'd0, "R4 timer idle");
    for (int m = 0; m < 8; m++) drive(3'(m), 0, 0, 1, 0, 3'd0, "R5 timer request");
    for (int d = 0; d < 8; d++) drive((d % 2) ? 3'd5 : 3'd4, 0, 0, 0, 0, 3'(d), "R6 fast div");
    drive(3'd0, 0, 0, 0, 0, 3'd5, "R6 div ignored outside internal");
    drive(3'd4, 0, 0, 0, 1, 3'd6, "R7 slow internal run");
    drive(3'd5, 0, 0, 0, 1, 3'd2, "R7 slow internal idle");
    drive(3'd4, 0, 0, 0, 0, 3'd3, "R7 back to fast");
    for (int m = 0; m < 8; m++) drive(3'(m), 0, 1, 0, 0, 3'd0, "R8 watchdog");
    drive(3'd6, 0, 0, 0, 1, 3'd7, "R9 sleep idle sources");
    drive(3'd6, 1, 1, 1, 0, 3'd0, "R9 sleep all requests");
    drive(3'd1, 0, 0, 0, 0, 3'd0, "R10 idle gates");
    drive(3'd7, 0, 0, 0, 1, 3'd4, "R11 unused code");
    repeat (3) @(posedge clk);
    @(negedge clk);
    mode = 3'd6; usb_on = 0; wdt_on = 0; tmr_req = 0; slow_pick = 0; div_in = 0;
    #1;
    check("R12 before edge", actual, model(3'd7, 0, 0, 0, 1, 3'd4));
    @(posedge clk); #1;
    check("R12 after edge", actual, model(3'd6, 0, 0, 0, 0, 3'd0));
    @(negedge clk);
    rst_n = 0;
    #1;
    check("R1 reset reapplied", actual, 11'b1_0_0_0_00_000_1_1);
    finish_run();
  end
endmodule